// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the byte-wide register face of an SMBus host controller. Software fills in a command byte, a target address byte (target in bits 7:1, read flag in bit 0), two data bytes and a control byte. It then sets the control start bit. The block turns that into one transaction request for a separate bus-side engine. The request carries a protocol code, the 7-bit target, the read flag, the command byte and the 16-bit data pair. When the engine reports completion or error, the block updates a write-one-to-clear status register, writes read results back into the data registers and drives a level interrupt.

When software leaves interrupts disabled, a start does not go to the bus at once. It only raises the busy flag. The next read of the status register returns that busy value, then drops busy and launches the transaction. A kill written through the control register withdraws any request, marks the operation as failed and drops busy. Bit timing on the wires and block-buffer sequencing belong to the engine, not to this block.

Top module: `smbus_host_regs`

## Requirements
- R1: Register offsets are as follows. Status is at 0x00, control at 0x02, command at 0x03, address at 0x04, data low at 0x05, data high at 0x06, block byte at 0x07 and auxiliary at 0x0D. The auxiliary register keeps only bits 1:0. Any other offset reads 0x00, and a write to it changes nothing. Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.
- R2: Control layout is: bit 0 interrupt enable, bit 1 kill, bits 4:2 protocol code, bit 6 start. A control read returns only bits 4:0, so the start bit always reads back as 0.
- R3: Status layout is: bit 0 busy, bit 1 done, bit 2 device error, bit 4 failed; the other bits are never set by this block. Writing status clears every bit written as 1, except busy, which such a write never clears.
- R4: If a start is written with interrupt enable set, no device error pending and a protocol code other than 7, the block does three things. It sets busy. It presents `req_valid` from the next cycle, with protocol, target, read flag, command and data {high, low} taken from the registers. It holds the request unchanged until `req_ready`.
- R5: On a successful `rsp_done`, the block sets done and clears busy. Byte (code 1) and byte-data (code 2) reads load data low from `rsp_data[7:0]`. Word reads (code 3) and process calls (code 4) load data low and data high from `rsp_data`.
- R6: An `rsp_done` with `rsp_error` set makes the block set device error, clear busy and leave the data registers unchanged.
- R7: A start while device error is already set, or with protocol code 7, issues no request and sets device error.
- R8: A start written with interrupt enable clear sets busy and issues no request. The next status read returns the status with busy set. After that read, busy is clear and the request is issued.
- R9: A control write with the kill bit set does four things. It withdraws any pending request, sets failed and clears busy. It also causes a later `rsp_done` for the withdrawn operation to be ignored.
- R10: `irq` is high exactly when interrupt enable is set and any status bit other than busy is set. It changes in the same cycle as the status register.
- R11: After reset, status, every register, `reg_rdata`, `irq` and `req_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| req_valid | output | 1 | Transaction request to the bus engine |
| req_ready | input | 1 | Engine accepts the request |
| req_proto | output | 3 | Protocol code |
| req_target | output | 7 | 7-bit target address |
| req_read | output | 1 | Read flag |
| req_cmd | output | 8 | Command byte |
| req_data | output | 16 | Data pair {high, low} |
| rsp_done | input | 1 | One-cycle completion pulse from the engine |
| rsp_error | input | 1 | Completion ended in error (valid with rsp_done) |
| rsp_data | input | 16 | Result word (valid with rsp_done) |

## Verification
The assertions assume four things about the inputs. The engine raises `rsp_done` only after it has accepted a request. A read strobe and a write strobe never fall in the same cycle. Software does not rewrite registers while a request is pending. A kill write is the only event that may drop `req_valid` before `req_ready`. The bench drives its engine model so that it answers only after acceptance. It issues register accesses as separate single-cycle strobes and changes registers only while the block is idle or deferred.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_CTL  = 2;
  localparam int unsigned OFS_CMD  = 3;
  localparam int unsigned OFS_ADR  = 4;
  localparam int unsigned OFS_DLO  = 5;
  localparam int unsigned OFS_DHI  = 6;
  localparam int unsigned OFS_BLK  = 7;
  localparam int unsigned OFS_AUX  = 13;

  localparam int unsigned STB_BUSY = 0;
  localparam int unsigned STB_DONE = 1;
  localparam int unsigned STB_DERR = 2;
  localparam int unsigned STB_FAIL = 4;

  localparam int unsigned CTB_IE   = 0;
  localparam int unsigned CTB_KILL = 1;
  localparam int unsigned CTB_GO   = 6;
  localparam int unsigned CT_KEEP  = 5;   // control bits that are stored and read back
  localparam int unsigned AUX_KEEP = 2;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WDATA = 3'd3,
    PR_PCALL = 3'd4,
    PR_BLOCK = 3'd5,
    PR_I2CRD = 3'd6,
    PR_NONE  = 3'd7
  } proto_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DEFER = 2'd1,
    SQ_REQ   = 2'd2,
    SQ_WAIT  = 2'd3
  } seq_e;

  typedef struct packed {
    logic set_busy;
    logic clr_busy;
    logic set_done;
    logic set_derr;
    logic set_fail;
  } stat_ev_t;

endpackage

// File: rtl/smbh_regfile.sv
module smbh_regfile
  import smbh_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [7:0]          stat_q,
  input  logic                wb_lo,
  input  logic                wb_hi,
  input  logic [15:0]         wb_data,
  output logic [CT_KEEP-1:0]  ctl_q,
  output logic [CT_KEEP-1:0]  ctl_cur,
  output logic [7:0]          cmd_q,
  output logic [7:0]          adr_q,
  output logic [7:0]          dlo_q,
  output logic [7:0]          dhi_q,
  output logic [7:0]          rdata
);

  logic [7:0]          blk_q;
  logic [AUX_KEEP-1:0] aux_q;
  logic [7:0]          rd_mux;
  logic                ctl_hit;

  assign ctl_hit = wr && (addr == ADDR_W'(OFS_CTL));
  assign ctl_cur = ctl_hit ? wdata[CT_KEEP-1:0] : ctl_q;

  always_comb begin
    rd_mux = 8'h00;
    if (addr == ADDR_W'(OFS_STAT))      rd_mux = stat_q;
    else if (addr == ADDR_W'(OFS_CTL))  rd_mux = {{(8-CT_KEEP){1'b0}}, ctl_q};
    else if (addr == ADDR_W'(OFS_CMD))  rd_mux = cmd_q;
    else if (addr == ADDR_W'(OFS_ADR))  rd_mux = adr_q;
    else if (addr == ADDR_W'(OFS_DLO))  rd_mux = dlo_q;
    else if (addr == ADDR_W'(OFS_DHI))  rd_mux = dhi_q;
    else if (addr == ADDR_W'(OFS_BLK))  rd_mux = blk_q;
    else if (addr == ADDR_W'(OFS_AUX))  rd_mux = {{(8-AUX_KEEP){1'b0}}, aux_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      cmd_q <= '0;
      adr_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
      blk_q <= '0;
      aux_q <= '0;
      rdata <= '0;
    end else begin
      ctl_q <= ctl_cur;
      if (wr) begin
        if (addr == ADDR_W'(OFS_CMD)) cmd_q <= wdata;
        if (addr == ADDR_W'(OFS_ADR)) adr_q <= wdata;
        if (addr == ADDR_W'(OFS_DLO)) dlo_q <= wdata;
        if (addr == ADDR_W'(OFS_DHI)) dhi_q <= wdata;
        if (addr == ADDR_W'(OFS_BLK)) blk_q <= wdata;
        if (addr == ADDR_W'(OFS_AUX)) aux_q <= wdata[AUX_KEEP-1:0];
      end
      // engine results take precedence over a same-cycle software write
      if (wb_lo) dlo_q <= wb_data[7:0];
      if (wb_hi) dhi_q <= wb_data[15:8];
      if (rd) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stat_wr,
  input  logic [7:0] wdata,
  input  stat_ev_t   ev,
  input  logic       ie_next,
  output logic [7:0] stat_q,
  output logic       irq
);

  logic [7:0] w1c_mask;
  logic [7:0] stat_n;

  // busy is excluded from software clearing
  assign w1c_mask = stat_wr ? (wdata & ~(8'h01 << STB_BUSY)) : 8'h00;

  always_comb begin
    stat_n = stat_q & ~w1c_mask;
    if (ev.set_busy) stat_n[STB_BUSY] = 1'b1;
    if (ev.clr_busy) stat_n[STB_BUSY] = 1'b0;
    if (ev.set_done) stat_n[STB_DONE] = 1'b1;
    if (ev.set_derr) stat_n[STB_DERR] = 1'b1;
    if (ev.set_fail) stat_n[STB_FAIL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      irq    <= ie_next && (stat_n[7:1] != 7'd0);
    end
  end

endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        kill,
  input  logic        stat_rd,
  input  logic        ie,
  input  logic [2:0]  proto,
  input  logic        derr,
  input  logic [7:0]  adr_q,
  input  logic [7:0]  cmd_q,
  input  logic [7:0]  dlo_q,
  input  logic [7:0]  dhi_q,
  input  logic        req_ready,
  input  logic        rsp_done,
  input  logic        rsp_error,
  input  logic [15:0] rsp_data,
  output logic        req_valid,
  output logic [2:0]  req_proto,
  output logic [6:0]  req_target,
  output logic        req_read,
  output logic [7:0]  req_cmd,
  output logic [15:0] req_data,
  output stat_ev_t    ev,
  output logic        wb_lo,
  output logic        wb_hi,
  output logic [15:0] wb_data
);

  seq_e st_q, st_n;
  logic launch;
  logic fin_ok;
  logic refuse;
  logic byte_back;
  logic word_back;

  assign refuse = derr || (proto == PR_NONE);

  always_comb begin
    ev     = '0;
    st_n   = st_q;
    launch = 1'b0;
    fin_ok = 1'b0;
    if (kill) begin
      st_n        = SQ_IDLE;
      ev.clr_busy = 1'b1;
      ev.set_fail = 1'b1;
    end else begin
      unique case (st_q)
        SQ_IDLE, SQ_DEFER: begin
          if (start) begin
            if (ie) begin
              if (refuse) begin
                ev.set_derr = 1'b1;
                st_n        = SQ_IDLE;
              end else begin
                ev.set_busy = 1'b1;
                launch      = 1'b1;
              end
            end else begin
              ev.set_busy = 1'b1;
              st_n        = SQ_DEFER;
            end
          end else if ((st_q == SQ_DEFER) && stat_rd) begin
            ev.clr_busy = 1'b1;
            if (refuse) begin
              ev.set_derr = 1'b1;
              st_n        = SQ_IDLE;
            end else begin
              launch = 1'b1;
            end
          end
        end
        SQ_REQ: begin
          if (req_ready) st_n = SQ_WAIT;
        end
        SQ_WAIT: begin
          if (rsp_done) begin
            st_n        = SQ_IDLE;
            ev.clr_busy = 1'b1;
            if (rsp_error) begin
              ev.set_derr = 1'b1;
            end else begin
              ev.set_done = 1'b1;
              fin_ok      = 1'b1;
            end
          end
        end
        default: st_n = SQ_IDLE;
      endcase
      if (launch) st_n = SQ_REQ;
    end
  end

  assign byte_back = req_read && ((req_proto == PR_BYTE) || (req_proto == PR_BDATA));
  assign word_back = (req_read && (req_proto == PR_WDATA)) || (req_proto == PR_PCALL);
  assign wb_lo     = fin_ok && (byte_back || word_back);
  assign wb_hi     = fin_ok && word_back;
  assign wb_data   = rsp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SQ_IDLE;
      req_valid  <= 1'b0;
      req_proto  <= '0;
      req_target <= '0;
      req_read   <= 1'b0;
      req_cmd    <= '0;
      req_data   <= '0;
    end else begin
      st_q      <= st_n;
      req_valid <= (st_n == SQ_REQ);
      if (launch) begin
        req_proto  <= proto;
        req_target <= adr_q[7:1];
        req_read   <= adr_q[0];
        req_cmd    <= cmd_q;
        req_data   <= {dhi_q, dlo_q};
      end
    end
  end

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbh_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_proto,
  output logic [6:0]        req_target,
  output logic              req_read,
  output logic [7:0]        req_cmd,
  output logic [15:0]       req_data,
  input  logic              rsp_done,
  input  logic              rsp_error,
  input  logic [15:0]       rsp_data
);

  logic [7:0]         stat_q;
  logic [CT_KEEP-1:0] ctl_q;
  logic [CT_KEEP-1:0] ctl_cur;
  logic [7:0]         cmd_q, adr_q, dlo_q, dhi_q;
  logic               ctl_wr, stat_wr, stat_rd;
  logic               kill_wr, start_wr;
  logic               wb_lo, wb_hi;
  logic [15:0]        wb_data;
  stat_ev_t           ev;

  assign ctl_wr   = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
  assign stat_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
  assign stat_rd  = reg_rd && (reg_addr == ADDR_W'(OFS_STAT));
  assign kill_wr  = ctl_wr && reg_wdata[CTB_KILL];
  assign start_wr = ctl_wr && reg_wdata[CTB_GO] && !reg_wdata[CTB_KILL];

  smbh_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .stat_q  (stat_q),
    .wb_lo   (wb_lo),
    .wb_hi   (wb_hi),
    .wb_data (wb_data),
    .ctl_q   (ctl_q),
    .ctl_cur (ctl_cur),
    .cmd_q   (cmd_q),
    .adr_q   (adr_q),
    .dlo_q   (dlo_q),
    .dhi_q   (dhi_q),
    .rdata   (reg_rdata)
  );

  smbh_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_wr),
    .kill       (kill_wr),
    .stat_rd    (stat_rd),
    .ie         (ctl_cur[CTB_IE]),
    .proto      (ctl_cur[4:2]),
    .derr       (stat_q[STB_DERR]),
    .adr_q      (adr_q),
    .cmd_q      (cmd_q),
    .dlo_q      (dlo_q),
    .dhi_q      (dhi_q),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .rsp_error  (rsp_error),
    .rsp_data   (rsp_data),
    .req_valid  (req_valid),
    .req_proto  (req_proto),
    .req_target (req_target),
    .req_read   (req_read),
    .req_cmd    (req_cmd),
    .req_data   (req_data),
    .ev         (ev),
    .wb_lo      (wb_lo),
    .wb_hi      (wb_hi),
    .wb_data    (wb_data)
  );

  smbh_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .stat_wr (stat_wr),
    .wdata   (reg_wdata),
    .ev      (ev),
    .ie_next (ctl_cur[CTB_IE]),
    .stat_q  (stat_q),
    .irq     (irq)
  );

endmodule

// File: rtl/smbh_checker.sv
module smbh_checker
  import smbh_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              irq,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_proto,
  input logic [7:0]        stat_q,
  input logic [CT_KEEP-1:0] ctl_q
);

  logic kill_seen;
  assign kill_seen = reg_wr && (reg_addr == ADDR_W'(OFS_CTL)) && reg_wdata[CTB_KILL];

  // R2: high control bits never read back
  assert_ctl_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == ADDR_W'(OFS_CTL))) |=> (reg_rdata[7:5] == 3'b000));

  // R4: a pending request is held steady until accepted or killed
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !kill_seen) |=> (req_valid && $stable(req_proto)));

  // R7: no request appears while device error was set at the launch decision
  assert_no_launch_on_err_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> !$past(stat_q[STB_DERR]));

  // R9: kill withdraws the request, marks failure, drops busy
  assert_kill_effect_R9: assert property (@(posedge clk) disable iff (rst)
    kill_seen |=> (!req_valid && stat_q[STB_FAIL] && !stat_q[STB_BUSY]));

  // R10: interrupt only with enable and a non-busy status cause
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctl_q[CTB_IE] && (stat_q[7:1] != 7'd0)));

endmodule

bind smbus_host_regs smbh_checker #(.ADDR_W(ADDR_W)) u_smbh_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_proto (req_proto),
  .stat_q    (stat_q),
  .ctl_q     (ctl_q)
);

// File: tb/smbus_host_regs_bench.sv
module smbus_host_regs_bench;

  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, req_valid, req_read;
  logic req_ready = 1'b0;
  logic [2:0] req_proto;
  logic [6:0] req_target;
  logic [7:0] req_cmd;
  logic [15:0] req_data;
  logic rsp_done = 1'b0, rsp_error = 1'b0;
  logic [15:0] rsp_data = '0;

  always #5 clk = ~clk;

  smbus_host_regs #(.ADDR_W(ADDR_W)) u_smbus_host_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .req_valid(req_valid),
    .req_ready(req_ready), .req_proto(req_proto), .req_target(req_target),
    .req_read(req_read), .req_cmd(req_cmd), .req_data(req_data),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_data(rsp_data)
  );

  // ---------------- reference model (behavioural) ----------------
  logic [7:0] m_stat, m_cmd, m_adr, m_lo, m_hi, m_blk, m_rdata;
  logic [4:0] m_ctl;
  logic [1:0] m_aux;
  int         m_mode;        // 0 idle, 1 deferred, 2 requesting, 3 waiting
  logic       m_reqv, m_irq, m_qr;
  logic [2:0] m_qp;
  logic [6:0] m_qt;
  logic [7:0] m_qc;
  logic [15:0] m_qd;

  function automatic logic [7:0] model_read(input int a);
    case (a)
      0:  return m_stat;
      2:  return {3'b000, m_ctl};
      3:  return m_cmd;
      4:  return m_adr;
      5:  return m_lo;
      6:  return m_hi;
      7:  return m_blk;
      13: return {6'b0, m_aux};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat = 0; m_cmd = 0; m_adr = 0; m_lo = 0; m_hi = 0; m_blk = 0; m_rdata = 0;
      m_ctl = 0; m_aux = 0; m_mode = 0; m_reqv = 0; m_irq = 0;
      m_qp = 0; m_qt = 0; m_qr = 0; m_qc = 0; m_qd = 0;
    end else begin
      automatic logic [7:0] o_stat = m_stat, o_adr = m_adr, o_cmd = m_cmd, o_lo = m_lo, o_hi = m_hi;
      automatic bit kill = 0, go = 0, bad, launch = 0;
      if (reg_rd) m_rdata = model_read(int'(reg_addr));
      if (reg_wr) begin
        case (int'(reg_addr))
          0:  m_stat = m_stat & ~(reg_wdata & 8'hFE);
          2:  begin m_ctl = reg_wdata[4:0]; kill = reg_wdata[1]; go = reg_wdata[6] && !reg_wdata[1]; end
          3:  m_cmd = reg_wdata;
          4:  m_adr = reg_wdata;
          5:  m_lo = reg_wdata;
          6:  m_hi = reg_wdata;
          7:  m_blk = reg_wdata;
          13: m_aux = reg_wdata[1:0];
          default: ;
        endcase
      end
      bad = o_stat[2] || (m_ctl[4:2] == 3'd7);
      if (kill) begin
        m_mode = 0; m_stat[0] = 0; m_stat[4] = 1;
      end else if (m_mode <= 1) begin
        if (go) begin
          if (m_ctl[0]) begin
            if (bad) begin m_stat[2] = 1; m_mode = 0; end
            else begin m_stat[0] = 1; launch = 1; end
          end else begin
            m_stat[0] = 1; m_mode = 1;
          end
        end else if (m_mode == 1 && reg_rd && reg_addr == 0) begin
          m_stat[0] = 0;
          if (bad) begin m_stat[2] = 1; m_mode = 0; end
          else launch = 1;
        end
      end else if (m_mode == 2) begin
        if (req_ready) m_mode = 3;
      end else if (m_mode == 3 && rsp_done) begin
        m_mode = 0; m_stat[0] = 0;
        if (rsp_error) m_stat[2] = 1;
        else begin
          m_stat[1] = 1;
          if ((m_qr && (m_qp == 3'd1 || m_qp == 3'd2 || m_qp == 3'd3)) || m_qp == 3'd4) m_lo = rsp_data[7:0];
          if ((m_qr && m_qp == 3'd3) || m_qp == 3'd4) m_hi = rsp_data[15:8];
        end
      end
      if (launch) begin
        m_mode = 2; m_qp = m_ctl[4:2]; m_qt = o_adr[7:1]; m_qr = o_adr[0];
        m_qc = o_cmd; m_qd = {o_hi, o_lo};
      end
      m_reqv = (m_mode == 2);
      m_irq  = m_ctl[0] && (m_stat[7:1] != 0);
    end
  end

  // ---------------- per-cycle comparison ----------------
  int cmp_chk = 0, cmp_fail = 0, launches = 0;
  bit mdl_on = 0;
  logic rv_prev = 0;
  always @(negedge clk) begin
    if (mdl_on) begin
      cmp_chk += 3;
      if (irq !== m_irq) begin cmp_fail++; $display("FAIL R10 irq actual=%0b expected=%0b", irq, m_irq); end
      if (req_valid !== m_reqv) begin cmp_fail++; $display("FAIL R4 req_valid actual=%0b expected=%0b", req_valid, m_reqv); end
      if (reg_rdata !== m_rdata) begin cmp_fail++; $display("FAIL R1 rdata actual=0x%0h expected=0x%0h", reg_rdata, m_rdata); end
      if (m_reqv) begin
        cmp_chk++;
        if ({req_proto, req_target, req_read, req_cmd, req_data} !== {m_qp, m_qt, m_qr, m_qc, m_qd}) begin
          cmp_fail++;
          $display("FAIL R4 request actual=0x%0h expected=0x%0h",
                   {req_proto, req_target, req_read, req_cmd, req_data}, {m_qp, m_qt, m_qr, m_qc, m_qd});
        end
      end
      if (req_valid && !rv_prev) launches++;
      rv_prev = req_valid;
    end
  end

  // ---------------- bus engine responder ----------------
  int rdy_lat = 0, dn_lat = 1, wcnt = 0, dcnt = 0;
  bit acc = 0, r_err = 0;
  logic [15:0] r_val = 16'h0;
  always @(negedge clk) begin
    rsp_done = 1'b0;
    if (acc) begin
      if (dcnt <= 1) begin rsp_done = 1'b1; rsp_error = r_err; rsp_data = r_val; acc = 0; end
      else dcnt--;
    end
    if (req_ready) begin
      acc = 1; dcnt = dn_lat; req_ready = 1'b0; wcnt = 0;
    end else if (req_valid) begin
      if (wcnt >= rdy_lat) req_ready = 1'b1; else wcnt++;
    end else wcnt = 0;
  end

  // ---------------- directed sequence ----------------
  int nchk = 0, nfail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", (nchk + cmp_chk) - (nfail + cmp_fail), nchk + cmp_chk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mdl_on = 1;
    idle(1);
    check("R11 irq after reset", irq, 0);
    check("R11 req_valid after reset", req_valid, 0);
    check("R11 rdata after reset", reg_rdata, 0);
    begin
      logic [7:0] v;
      int l0;
      rd(0, v); check("R11 status after reset", v, 8'h00);

      // R1 plain registers and unmapped offsets
      wr(3, 8'h10); wr(4, 8'h51); wr(5, 8'h11); wr(6, 8'h22); wr(7, 8'hC3); wr(13, 8'hFF);
      wr(1, 8'h77); wr(9, 8'h55);
      rd(3, v); check("R1 command", v, 8'h10);
      rd(4, v); check("R1 address", v, 8'h51);
      rd(7, v); check("R1 block byte", v, 8'hC3);
      rd(13, v); check("R1 aux keeps two bits", v, 8'h03);
      rd(1, v); check("R1 unmapped reads zero", v, 8'h00);
      rd(9, v); check("R1 unmapped write ignored", v, 8'h00);

      // R2 control readback
      wr(2, 8'hA4); rd(2, v); check("R2 control low bits only", v, 8'h04);

      // R4 / R5 immediate word read
      rdy_lat = 2; dn_lat = 3; r_err = 0; r_val = 16'hBEEF;
      wr(2, 8'h4D);
      check("R4 req_valid after start", req_valid, 1);
      check("R4 request fields", {req_proto, req_target, req_read, req_cmd, req_data},
            {3'd3, 7'h28, 1'b1, 8'h10, 16'h2211});
      idle(12);
      rd(0, v); check("R5 status done", v, 8'h02);
      check("R10 irq on done", irq, 1);
      rd(5, v); check("R5 word low", v, 8'hEF);
      rd(6, v); check("R5 word high", v, 8'hBE);
      rd(2, v); check("R2 start reads zero", v, 8'h0D);

      // R3 clear
      wr(0, 8'hFF); rd(0, v); check("R3 status cleared", v, 8'h00);
      check("R10 irq cleared", irq, 0);

      // R5 byte-data read touches only the low byte
      r_val = 16'h1234; rdy_lat = 0; dn_lat = 1;
      wr(2, 8'h49); idle(6);
      rd(5, v); check("R5 byte-data low", v, 8'h34);
      rd(6, v); check("R5 byte-data high kept", v, 8'hBE);
      wr(0, 8'h02);

      // R6 engine error
      r_err = 1; r_val = 16'hAAAA;
      wr(2, 8'h49); idle(6);
      rd(0, v); check("R6 device error", v, 8'h04);
      rd(5, v); check("R6 data unchanged", v, 8'h34);
      r_err = 0;

      // R7 refused starts
      l0 = launches;
      wr(2, 8'h49); idle(6);
      check("R7 no request with error pending", launches, l0);
      rd(0, v); check("R7 error kept", v, 8'h04);
      wr(0, 8'h04);
      wr(2, 8'h5D); idle(6);
      check("R7 no request for code 7", launches, l0);
      rd(0, v); check("R7 code 7 error", v, 8'h04);
      wr(0, 8'hFF);

      // R8 deferred start, R3 busy survives status write
      r_val = 16'h0066;
      wr(2, 8'h44); idle(4);
      check("R8 no request before status read", launches, l0);
      wr(0, 8'hFF);
      rd(0, v); check("R3 R8 busy seen on deferred read", v, 8'h01);
      check("R8 request after status read", req_valid, 1);
      idle(6);
      rd(0, v); check("R8 done after deferred run", v, 8'h02);
      check("R10 no irq without enable", irq, 0);
      rd(5, v); check("R5 byte read low", v, 8'h66);
      wr(0, 8'hFF);

      // R9 kill while requesting
      rdy_lat = 30;
      wr(2, 8'h49);
      check("R9 request pending", req_valid, 1);
      wr(2, 8'h03);
      check("R9 request withdrawn", req_valid, 0);
      rd(0, v); check("R9 failed set busy clear", v, 8'h10);
      check("R10 irq on failed", irq, 1);
      idle(40);
      wr(0, 8'hFF);

      // R9 kill while waiting; late completion ignored
      rdy_lat = 0; dn_lat = 20; r_val = 16'h9999;
      wr(2, 8'h49); idle(5);
      wr(2, 8'h03); idle(30);
      rd(0, v); check("R9 late completion ignored", v, 8'h10);
      rd(5, v); check("R9 data kept", v, 8'h66);

      // R10 enable off masks the cause
      wr(2, 8'h00);
      check("R10 irq masked", irq, 0);
      idle(3);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", (nchk + cmp_chk) - (nfail + cmp_fail) - 1, nchk + cmp_chk);
    $finish;
  end

endmodule